// File: doc/BRIEF.md
# Six-Pin General-Purpose I/O Port Controller

This block is the digital control core of a small microcontroller's six-pin I/O port. Software reaches it over a simple register bus with an address, a write enable, write data, a read strobe and registered read data. Through that bus it reaches five state elements. The first is a per-pin direction register, where 1 makes a pin an input and 0 makes it an output. The second is a per-pin analog-select register. The third is a per-pin weak pull-up enable register. The fourth is a single global pull-up disable bit. The fifth is the output data latch.

From these registers the block drives, for each pin, an output enable, an output value and a pull-up enable for the pad ring. Pin levels coming back from the pads pass through a two-flop synchronizer. When software reads the port, pins marked analog return 0.

Two configuration inputs change what the block presents. The first, `osc_xtal`, means pins 4 and 5 belong to a crystal or resonator. The second, `pin3_is_reset`, means pin 3 serves as the external reset pin. Pin 3 is input-only. Software never controls its pull-up: the pull-up follows the reset configuration.

The register addresses are fixed:

| Address | Register |
|---|---|
| 0 | port (write: output latch; read: pins) |
| 1 | direction |
| 2 | analog select |
| 3 | pull-up enable |
| 4 | control (bit 0 = global pull-up disable) |
| other | read as 0 |

Top module: `pinbank_ctrl`

## Requirements
- R1: After reset, the direction register reads 0x3F. No pin is driven, no pull-up is on, the output latch is 0 and the analog-select register reads 0.
- R2: For pins 0, 1 and 2, and for pins 4 and 5 when `osc_xtal` is 0, `pad_oe` is the inverse of the direction bit: 0 means output and 1 means input. `pad_out` always equals the output latch, which is written at address 0.
- R3: Direction read-back (address 1) has bits 7 and 6 at 0 and bit 3 always at 1. Pin 3 is never driven.
- R4: While `osc_xtal` is 1, direction bits 5 and 4 read back as 1 and pins 4 and 5 are not driven, whatever value is stored. When `osc_xtal` returns to 0, the stored bits apply again.
- R5: A pin whose analog-select bit (address 2) is 1 reads 0 at address 0. If its direction bit is 0, it still drives its latch value.
- R6: A port read returns the pad levels delayed by two synchronizer flops, with bits 7 and 6 at 0. A pad change applied before clock edge k appears in a read strobed at edge k+2, and not in one strobed at edge k+1.
- R7: For each pin other than pin 3, `pad_pu` is 1 only when the global disable bit is 0, that pin's pull-up enable bit (address 3) is 1, and the pin is an input. It is 0 whenever the pin is driven.
- R8: `pad_pu[3]` equals `pin3_is_reset`, regardless of any register. Bit 3 of the pull-up enable register reads 0.
- R9: Read data updates on the clock edge that samples `bus_rd`. It shows the register values from before any write on that same edge, and it holds while `bus_rd` is low. Unmapped addresses 5 to 7 read 0.
- R10: Control bit 0, the global pull-up disable, resets to 1. Bits 7 to 1 of the control register read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Register address |
| bus_we | input | 1 | Write enable |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Registered read data |
| osc_xtal | input | 1 | Pins 4 and 5 are taken by a crystal or resonator |
| pin3_is_reset | input | 1 | Pin 3 is configured as the reset pin |
| pad_in | input | 6 | Pad input levels (asynchronous) |
| pad_oe | output | 6 | Per-pin output enable |
| pad_out | output | 6 | Per-pin output value |
| pad_pu | output | 6 | Per-pin weak pull-up enable |

## Verification
The bench sets the analog bit on a pin that is also an output. A design that gated the driver together with the read, or failed to mask the read, would either release the pin or return its level.

It reads the direction register while the oscillator mode is on and then off. A design that forced the stored bits instead of only the read-back would lose the software value.

It times a pad change against reads one and two edges later, which exposes a synchronizer with the wrong depth. It also walks through the pull-up conditions, including a pin that switches to output, the pin 3 reset path and the global disable. A design that missed one of these would leave a pull-up fighting a driver, or let software touch the reset pin's pull-up.

// File: rtl/pinbank_pkg.sv
package pinbank_pkg;
    localparam int PB_DW = 8;
    localparam int PB_AW = 3;

    typedef enum logic [PB_AW-1:0] {
        REG_PORT   = 3'd0,
        REG_DIR    = 3'd1,
        REG_ANALOG = 3'd2,
        REG_PULLEN = 3'd3,
        REG_CTRL   = 3'd4
    } pb_reg_e;
endpackage

// File: rtl/pinbank_sync.sv
module pinbank_sync #(
    parameter int W      = 6,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);
    logic [W-1:0] stage_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[0] <= '0;
        else        stage_q[0] <= d_async;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= stage_q[s-1];
        end
    end

    assign q_sync = stage_q[STAGES-1];
endmodule

// File: rtl/pinbank_pins.sv
module pinbank_pins #(
    parameter int NPINS      = 6,
    parameter int INONLY_PIN = 3,
    parameter int OSC_LO     = 4,
    parameter int OSC_HI     = 5
) (
    input  logic [NPINS-1:0] dir_q,
    input  logic [NPINS-1:0] pullen_q,
    input  logic [NPINS-1:0] latch_q,
    input  logic             pull_dis,
    input  logic             osc_xtal,
    input  logic             pin3_is_reset,
    output logic [NPINS-1:0] dir_eff,
    output logic [NPINS-1:0] pad_oe,
    output logic [NPINS-1:0] pad_out,
    output logic [NPINS-1:0] pad_pu
);
    for (genvar g = 0; g < NPINS; g++) begin : g_pin
        if (g == INONLY_PIN) begin : g_inonly
            assign dir_eff[g] = 1'b1;
            assign pad_pu[g]  = pin3_is_reset;
        end else if (g >= OSC_LO && g <= OSC_HI) begin : g_osc
            assign dir_eff[g] = dir_q[g] | osc_xtal;
            assign pad_pu[g]  = ~pull_dis & pullen_q[g] & dir_eff[g];
        end else begin : g_plain
            assign dir_eff[g] = dir_q[g];
            assign pad_pu[g]  = ~pull_dis & pullen_q[g] & dir_eff[g];
        end
        assign pad_oe[g]  = ~dir_eff[g];
        assign pad_out[g] = latch_q[g];
    end
endmodule

// File: rtl/pinbank_regs.sv
module pinbank_regs
    import pinbank_pkg::*;
#(
    parameter int NPINS      = 6,
    parameter int DW         = 8,
    parameter int AW         = 3,
    parameter int INONLY_PIN = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    bus_addr,
    input  logic             bus_we,
    input  logic [DW-1:0]    bus_wdata,
    input  logic             bus_rd,
    output logic [DW-1:0]    bus_rdata,
    input  logic [NPINS-1:0] pins_sync,
    input  logic [NPINS-1:0] dir_eff,
    output logic [NPINS-1:0] dir_q,
    output logic [NPINS-1:0] analog_q,
    output logic [NPINS-1:0] pullen_q,
    output logic [NPINS-1:0] latch_q,
    output logic             pull_dis_q
);
    localparam logic [NPINS-1:0] PULLEN_IMPL = ~(NPINS'(1) << INONLY_PIN);

    logic [DW-1:0] rd_next;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q      <= '1;
            analog_q   <= '0;
            pullen_q   <= '1;
            latch_q    <= '0;
            pull_dis_q <= 1'b1;
        end else if (bus_we) begin
            unique case (pb_reg_e'(bus_addr))
                REG_PORT:   latch_q    <= bus_wdata[NPINS-1:0];
                REG_DIR:    dir_q      <= bus_wdata[NPINS-1:0];
                REG_ANALOG: analog_q   <= bus_wdata[NPINS-1:0];
                REG_PULLEN: pullen_q   <= bus_wdata[NPINS-1:0];
                REG_CTRL:   pull_dis_q <= bus_wdata[0];
                default: ;
            endcase
        end
    end

    always_comb begin
        rd_next = '0;
        unique case (pb_reg_e'(bus_addr))
            REG_PORT:   rd_next[NPINS-1:0] = pins_sync & ~analog_q;
            REG_DIR:    rd_next[NPINS-1:0] = dir_eff;
            REG_ANALOG: rd_next[NPINS-1:0] = analog_q;
            REG_PULLEN: rd_next[NPINS-1:0] = pullen_q & PULLEN_IMPL;
            REG_CTRL:   rd_next[0]         = pull_dis_q;
            default:    rd_next            = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_next;
    end
endmodule

// File: rtl/pinbank_ctrl.sv
module pinbank_ctrl
    import pinbank_pkg::*;
#(
    parameter int NPINS       = 6,
    parameter int DW          = PB_DW,
    parameter int AW          = PB_AW,
    parameter int SYNC_STAGES = 2,
    parameter int INONLY_PIN  = 3,
    parameter int OSC_LO      = 4,
    parameter int OSC_HI      = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    bus_addr,
    input  logic             bus_we,
    input  logic [DW-1:0]    bus_wdata,
    input  logic             bus_rd,
    output logic [DW-1:0]    bus_rdata,
    input  logic             osc_xtal,
    input  logic             pin3_is_reset,
    input  logic [NPINS-1:0] pad_in,
    output logic [NPINS-1:0] pad_oe,
    output logic [NPINS-1:0] pad_out,
    output logic [NPINS-1:0] pad_pu
);
    logic [NPINS-1:0] pins_sync;
    logic [NPINS-1:0] dir_q;
    logic [NPINS-1:0] analog_q;
    logic [NPINS-1:0] pullen_q;
    logic [NPINS-1:0] latch_q;
    logic [NPINS-1:0] dir_eff;
    logic             pull_dis_q;

    pinbank_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (pad_in),
        .q_sync  (pins_sync)
    );

    pinbank_regs #(.NPINS(NPINS), .DW(DW), .AW(AW), .INONLY_PIN(INONLY_PIN)) regs_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_addr   (bus_addr),
        .bus_we     (bus_we),
        .bus_wdata  (bus_wdata),
        .bus_rd     (bus_rd),
        .bus_rdata  (bus_rdata),
        .pins_sync  (pins_sync),
        .dir_eff    (dir_eff),
        .dir_q      (dir_q),
        .analog_q   (analog_q),
        .pullen_q   (pullen_q),
        .latch_q    (latch_q),
        .pull_dis_q (pull_dis_q)
    );

    pinbank_pins #(.NPINS(NPINS), .INONLY_PIN(INONLY_PIN), .OSC_LO(OSC_LO), .OSC_HI(OSC_HI)) pins_i (
        .dir_q         (dir_q),
        .pullen_q      (pullen_q),
        .latch_q       (latch_q),
        .pull_dis      (pull_dis_q),
        .osc_xtal      (osc_xtal),
        .pin3_is_reset (pin3_is_reset),
        .dir_eff       (dir_eff),
        .pad_oe        (pad_oe),
        .pad_out       (pad_out),
        .pad_pu        (pad_pu)
    );
endmodule

// File: rtl/pinbank_ctrl_chk.sv
module pinbank_ctrl_chk #(
    parameter int NPINS      = 6,
    parameter int DW         = 8,
    parameter int AW         = 3,
    parameter int INONLY_PIN = 3,
    parameter int OSC_LO     = 4,
    parameter int OSC_HI     = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic [AW-1:0]    bus_addr,
    input logic             bus_we,
    input logic             bus_rd,
    input logic [DW-1:0]    bus_rdata,
    input logic             osc_xtal,
    input logic             pin3_is_reset,
    input logic [NPINS-1:0] pad_oe,
    input logic [NPINS-1:0] pad_pu
);
    assert_pin3_undriven_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !pad_oe[INONLY_PIN]);

    assert_osc_released_R4: assert property (@(posedge clk) disable iff (!rst_n)
        osc_xtal |-> (pad_oe[OSC_HI:OSC_LO] == '0));

    assert_no_pull_on_driver_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe & pad_pu) == '0);

    assert_pin3_pull_follows_cfg_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pad_pu[INONLY_PIN] == pin3_is_reset);

    assert_rdata_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));

    assert_rdata_top_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[DW-1:NPINS] == '0);

    assert_unmapped_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr > AW'(4)) |=> (bus_rdata == '0));

    logic unused_ok;
    assign unused_ok = bus_we;
endmodule

bind pinbank_ctrl pinbank_ctrl_chk #(
    .NPINS(NPINS), .DW(DW), .AW(AW),
    .INONLY_PIN(INONLY_PIN), .OSC_LO(OSC_LO), .OSC_HI(OSC_HI)
) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_addr      (bus_addr),
    .bus_we        (bus_we),
    .bus_rd        (bus_rd),
    .bus_rdata     (bus_rdata),
    .osc_xtal      (osc_xtal),
    .pin3_is_reset (pin3_is_reset),
    .pad_oe        (pad_oe),
    .pad_pu        (pad_pu)
);

// File: tb/pinbank_ctrl_tb_top.sv
`timescale 1ns/1ps
module pinbank_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] bus_addr = '0;
    logic       bus_we = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_rdata;
    logic       osc_xtal = 1'b0;
    logic       pin3_is_reset = 1'b0;
    logic [5:0] pad_in = '0;
    logic [5:0] pad_oe, pad_out, pad_pu;

    int checks = 0;
    int failures = 0;

    // behavioural reference state
    int m_dir, m_ana, m_pul, m_lat, m_dis, m_s1, m_s2, m_rd;

    always #2 clk = ~clk;

    pinbank_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .osc_xtal(osc_xtal), .pin3_is_reset(pin3_is_reset), .pad_in(pad_in),
        .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu)
    );

    function automatic int dir_view();
        int v = (m_dir & 'h3F) | 'h08;
        if (osc_xtal) v = v | 'h30;
        return v;
    endfunction

    function automatic int exp_pu();
        int v = 0;
        for (int i = 0; i < 6; i++) begin
            if (i == 3) begin
                if (pin3_is_reset) v = v | 'h08;
            end else if (m_dis == 0 && m_pul[i] && dir_view() >> i & 1) begin
                v = v | (1 << i);
            end
        end
        return v;
    endfunction

    function automatic int read_of(int a);
        case (a)
            0: return m_s2 & ~m_ana & 'h3F;
            1: return dir_view();
            2: return m_ana;
            3: return m_pul & 'h37;
            4: return m_dis;
            default: return 0;
        endcase
    endfunction

    task automatic chk(int got, int exp, string tag);
        checks++;
        if (got != exp) begin
            failures++;
            $display("FAIL %s got=0x%0h exp=0x%0h", tag, got, exp);
        end
    endtask

    task automatic model_reset();
        m_dir = 'h3F; m_ana = 0; m_pul = 'h3F; m_lat = 0; m_dis = 1;
        m_s1 = 0; m_s2 = 0; m_rd = 0;
    endtask

    // one clock: drive at negedge, model the edge, compare at next negedge
    task automatic step(int a, int we, int wd, int rd);
        int pads;
        bus_addr = 3'(a); bus_we = 1'(we); bus_wdata = 8'(wd); bus_rd = 1'(rd);
        pads = int'(pad_in);
        @(posedge clk);
        if (rd != 0) m_rd = read_of(a);
        if (we != 0) begin
            case (a)
                0: m_lat = wd & 'h3F;
                1: m_dir = wd & 'h3F;
                2: m_ana = wd & 'h3F;
                3: m_pul = wd & 'h3F;
                4: m_dis = wd & 1;
                default: ;
            endcase
        end
        m_s2 = m_s1; m_s1 = pads;
        @(negedge clk);
        bus_we = 1'b0; bus_rd = 1'b0;
        chk(int'(pad_oe),  ~dir_view() & 'h3F, "R2 pad_oe");
        chk(int'(pad_out), m_lat,              "R5 pad_out");
        chk(int'(pad_pu),  exp_pu(),           "R7 pad_pu");
        chk(int'(bus_rdata), m_rd,             "R9 bus_rdata");
    endtask

    task automatic rd(int a);
        step(a, 0, 0, 1);
    endtask

    task automatic wr(int a, int d);
        step(a, 1, d, 0);
    endtask

    initial begin
        #400000;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        // R1 state while still in reset
        chk(int'(pad_oe), 0, "R1 oe at reset");
        chk(int'(pad_pu), 0, "R1 pu at reset");
        chk(int'(pad_out), 0, "R1 latch at reset");
        rst_n = 1'b1;
        @(negedge clk);

        rd(1);  chk(int'(bus_rdata), 'h3F, "R1 direction reset");
        rd(2);  chk(int'(bus_rdata), 'h00, "R1 analog reset");
        rd(4);  chk(int'(bus_rdata), 'h01, "R10 control reset");

        // R2 / R3: all outputs, pin 3 stays input
        wr(1, 'hC0);
        chk(int'(pad_oe), 'h37, "R2 oe all outputs");
        rd(1);  chk(int'(bus_rdata), 'h08, "R3 direction readback");
        wr(0, 'hEA);
        chk(int'(pad_out), 'h2A, "R2 latch value");

        // R4 oscillator mode
        osc_xtal = 1'b1;
        rd(1);  chk(int'(bus_rdata), 'h38, "R4 direction readback osc");
        chk(int'(pad_oe), 'h07, "R4 osc pins released");
        osc_xtal = 1'b0;
        rd(1);  chk(int'(bus_rdata), 'h08, "R4 stored bits restored");

        // R6 synchronizer timing, R5 analog masking
        wr(1, 'h3F);
        pad_in = 6'h15;
        rd(0);  chk(int'(bus_rdata), 'h00, "R6 read at edge k");
        rd(0);  chk(int'(bus_rdata), 'h00, "R6 read at edge k+1");
        rd(0);  chk(int'(bus_rdata), 'h15, "R6 read at edge k+2");
        wr(2, 'h05);
        rd(0);  chk(int'(bus_rdata), 'h10, "R5 analog pins read 0");
        wr(1, 'h00);
        chk(int'(pad_oe) & 'h05, 'h05, "R5 analog pin still driven");
        chk(int'(pad_out), 'h2A, "R5 analog pin drives latch");

        // R7 pull-ups
        wr(1, 'h3F);
        wr(3, 'h3F);
        chk(int'(pad_pu), 'h00, "R7 global disable holds pulls off");
        wr(4, 'h00);
        chk(int'(pad_pu), 'h37, "R7 pulls on inputs");
        wr(1, 'h0F);
        chk(int'(pad_pu), 'h07, "R7 pulls off on outputs");

        // R8 pin 3 pull-up
        rd(3);  chk(int'(bus_rdata), 'h37, "R8 pull enable bit3 reads 0");
        pin3_is_reset = 1'b1;
        wr(4, 'h01);
        chk(int'(pad_pu), 'h08, "R8 pin3 pull with reset pin");
        pin3_is_reset = 1'b0;
        wr(3, 'h08);
        chk(int'(pad_pu) & 'h08, 0, "R8 pin3 pull ignores software");

        // R9 unmapped and hold
        rd(7);  chk(int'(bus_rdata), 'h00, "R9 unmapped read");
        rd(4);
        step(1, 0, 0, 0); chk(int'(bus_rdata), 'h01, "R9 hold without strobe");
        // R9 read sees value before same-edge write
        step(2, 1, 'h3F, 1); chk(int'(bus_rdata), 'h05, "R9 read before write");

        // random traffic compared against the model each clock
        for (int n = 0; n < 400; n++) begin
            if ($urandom_range(0, 7) == 0) osc_xtal = 1'($urandom_range(0, 1));
            if ($urandom_range(0, 7) == 0) pin3_is_reset = 1'($urandom_range(0, 1));
            pad_in = 6'($urandom);
            step(int'($urandom_range(0, 7)), int'($urandom_range(0, 1)),
                 int'($urandom_range(0, 255)), int'($urandom_range(0, 1)));
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule